// File: doc/BRIEF.md
# Asynchronous Serial Byte Transmitter

This block turns one 8-bit byte into a framed asynchronous serial waveform on a single line. A frame opens with a low start bit, carries the eight data bits least significant first, and closes with a high stop bit. There is no parity. Every bit lasts a whole number of system clocks: the clock rate divided by the baud rate, both given as parameters.

A client requests a transfer with a one-cycle send strobe. The byte on the data input is captured on that edge, so the client may change the input freely while the frame is on the line. A busy output covers the whole frame. A one-cycle done pulse follows the end of the stop bit, and the client may issue the next strobe in that same cycle to keep frames back to back.

An enable input gates the transmitter. While enable is low, send strobes are ignored and the line is held high. Dropping enable in the middle of a frame abandons that frame without a done pulse.

Top module: `serial_byte_tx`

## Requirements
- R1: After a synchronous active-low reset, and whenever no frame is in progress, `line_out` is 1, `busy` is 0 and `done` is 0.
- R2: A clock edge with `send_strobe`=1, `tx_enable`=1 and `busy`=0 accepts a transfer: `busy` is 1 from the next cycle and `line_out` is 0 (start bit) in that cycle.
- R3: The frame is 10 bits in this order: start bit 0, data bits 0 to 7 (bit 0 first), stop bit 1. Each bit holds for exactly CLK_HZ/BAUD_HZ clock cycles, counted from the cycle after the accepting edge.
- R4: The byte sent is the value of `send_byte` at the accepting edge; later changes on `send_byte` do not alter the frame in progress.
- R5: `busy` stays 1 for exactly 10*CLK_HZ/BAUD_HZ consecutive cycles for a frame that completes.
- R6: `done` is 1 for exactly one cycle, the first cycle after the stop bit ends, and `busy` is 0 in that cycle.
- R7: A `send_strobe` while `tx_enable`=0 is ignored: `busy` stays 0 and `line_out` stays 1.
- R8: A `send_strobe` while `busy`=1 is ignored and does not disturb the bits or timing of the frame in progress.
- R9: While `tx_enable`=0, `line_out` is 1. If `tx_enable` is 0 at an edge during a frame, the frame is abandoned: `busy` goes to 0 after that edge and no `done` pulse follows.
- R10: A strobe in the `done` cycle is accepted, and the new frame starts in the next cycle with the same exact bit timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_enable | input | 1 | Transmitter enable; low blocks requests and holds the line high |
| send_strobe | input | 1 | One-cycle transfer request |
| send_byte | input | 8 | Byte to send, captured on the accepting edge |
| line_out | output | 1 | Serial output, idles high |
| busy | output | 1 | High while a frame is on the line |
| done | output | 1 | One-cycle pulse after the stop bit ends |

## Verification
After an accepting edge, `busy` and the start bit are due one cycle later. Data bit k (0 to 7) is due `(k+1)*DIV+1` cycles after that edge, and `done` is due `10*DIV+1` cycles after it. `line_out` also follows `tx_enable` within the same cycle. The bench keeps a behavioural model with a cycle position inside the frame. It updates the model on each rising edge from the inputs applied half a cycle earlier. It compares all three outputs shortly after each falling edge, so every expectation lands in the cycle the register chain produces it. Directed checks for ignored strobes and abandoned frames read `busy` and `line_out` in the cycles right after the stimulus.

// File: rtl/sbt_pkg.sv
// Package: shared constants and helpers for the serial byte transmitter.
// Assumes a fixed 8-bit payload with one start and one stop bit.
package sbt_pkg;

    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = DATA_W + 2;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_t;

    // Build the on-line frame, bit 0 leaves first: start(0), data LSB first, stop(1).
    function automatic logic [FRAME_BITS-1:0] build_frame(input logic [DATA_W-1:0] b);
        return {1'b1, b, 1'b0};
    endfunction

endpackage

// File: rtl/sbt_bit_timer.sv
// Module: bit-period timer. Counts DIV clocks per bit and pulses `tick` on the
// last clock of each bit. `restart` re-aligns the count to the start of a bit.
// Assumes DIV >= 2 and that `run` is low whenever no frame is active.
module sbt_bit_timer #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    // Cycle counter within the current bit; cleared on restart and at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (run) begin
            if (cnt_q == CNT_LAST) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Last clock of a bit period.
    always_comb begin
        tick = run && (cnt_q == CNT_LAST);
    end

    // R3: counter never leaves 0..DIV-1
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);

    // R10: a restart always begins a fresh bit at count zero
    p_restart_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

endmodule

// File: rtl/sbt_frame_shift.sv
// Module: frame shifter. Loads a full frame for a byte and presents bit 0 on
// `ser_bit`. Each `step` shifts one bit out, filling with the idle level.
// `at_last` flags the stop bit position. Assumes load and step are exclusive.
module sbt_frame_shift
    import sbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic              step,
    output logic              ser_bit,
    output logic              at_last
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] sr_q;
    logic [IDX_W-1:0]      idx_q;

    // Frame register: capture on load, shift out on each bit step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '1;
        end else if (load) begin
            sr_q <= build_frame(data);
        end else if (step) begin
            sr_q <= {1'b1, sr_q[FRAME_BITS-1:1]};
        end
    end

    // Bit position within the frame, restarted on every load.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            idx_q <= '0;
        end else if (step && idx_q != IDX_LAST) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Current line bit and stop-bit marker.
    always_comb begin
        ser_bit = sr_q[0];
        at_last = (idx_q == IDX_LAST);
    end

    // R4: captured frame is untouched between load and step
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(sr_q));

    // R3: load always presents the start bit first
    p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sr_q[0] == 1'b0 && idx_q == '0));

    // R3: position stays within the frame
    p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_LAST);

endmodule

// File: rtl/serial_byte_tx.sv
// Module: asynchronous serial byte transmitter (top). Accepts a one-cycle send
// strobe when enabled and idle, sends start/8 data/stop bits at CLK_HZ/BAUD_HZ
// clocks per bit, then pulses done. Dropping enable abandons a frame.
// Assumes CLK_HZ/BAUD_HZ >= 2 and a synchronous active-low reset.
module serial_byte_tx #(
    parameter int CLK_HZ  = 32,
    parameter int BAUD_HZ = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_enable,
    input  logic       send_strobe,
    input  logic [7:0] send_byte,
    output logic       line_out,
    output logic       busy,
    output logic       done
);
    import sbt_pkg::*;

    localparam int DIV = CLK_HZ / BAUD_HZ;

    tx_state_t state_q;
    logic      done_q;
    logic      accept;
    logic      run;
    logic      bit_tick;
    logic      ser_bit;
    logic      at_last;
    logic      frame_end;

    // Request qualification and frame progress conditions.
    always_comb begin
        busy      = (state_q == TX_SEND);
        accept    = tx_enable && send_strobe && !busy;
        run       = busy && tx_enable;
        frame_end = bit_tick && at_last;
    end

    sbt_bit_timer #(
        .DIV (DIV)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .run     (run),
        .tick    (bit_tick)
    );

    sbt_frame_shift u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .data    (send_byte),
        .step    (bit_tick),
        .ser_bit (ser_bit),
        .at_last (at_last)
    );

    // Transfer state: enter on accept, leave at stop-bit end or on disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else if (accept) begin
            state_q <= TX_SEND;
        end else if (busy && (!tx_enable || frame_end)) begin
            state_q <= TX_IDLE;
        end
    end

    // Completion pulse, one cycle after the stop bit's final clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= frame_end;
        end
    end

    // Line driver: frame bit while enabled and sending, idle high otherwise.
    always_comb begin
        line_out = (busy && tx_enable) ? ser_bit : 1'b1;
        done     = done_q;
    end

    // R1: idle line is high
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line_out);

    // R2: accepted request starts a frame with the start bit
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_enable && send_strobe && !busy) |=> (busy && (line_out || !tx_enable) == !tx_enable));

    // R6: done is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: done only while idle
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: disabled idle transmitter stays idle
    p_ignore_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !tx_enable) |=> !busy);

    // R8: enabled frame is not ended early by anything but its stop bit
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tx_enable && !frame_end) |=> busy);

    // R9: disabled line is high
    p_disabled_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |-> line_out);

    // R9: disable mid-frame abandons without completion
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_enable) |=> (!busy && !done));

endmodule

// File: tb/serial_byte_tx_bench.sv
// Bench: behavioural reference model updated on each rising edge, compared
// with the design shortly after every falling edge.
module serial_byte_tx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 32;
    localparam int BAUD_HZ    = 4;
    localparam int DIV        = CLK_HZ / BAUD_HZ;
    localparam int FRAME_CYC  = 10 * DIV;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_enable = 1'b0;
    logic       send_strobe = 1'b0;
    logic [7:0] send_byte = 8'h00;
    logic       line_out;
    logic       busy;
    logic       done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    // Reference model state
    bit       m_busy = 0;
    bit       m_done = 0;
    int       m_pos = 0;
    bit [7:0] m_byte = 8'h00;

    serial_byte_tx #(
        .CLK_HZ  (CLK_HZ),
        .BAUD_HZ (BAUD_HZ)
    ) u_serial_byte_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_enable   (tx_enable),
        .send_strobe (send_strobe),
        .send_byte   (send_byte),
        .line_out    (line_out),
        .busy        (busy),
        .done        (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model: advance one cycle per rising edge from the applied inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_pos = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (!tx_enable) begin
                    m_busy = 0;
                end else if (m_pos == FRAME_CYC - 1) begin
                    m_busy = 0;
                    m_done = 1;
                end else begin
                    m_pos++;
                end
            end else if (tx_enable && send_strobe) begin
                m_busy = 1;
                m_pos  = 0;
                m_byte = send_byte;
            end
        end
    end

    function automatic bit model_line();
        int b;
        if (!(m_busy && tx_enable)) return 1'b1;
        b = m_pos / DIV;
        if (b == 0) return 1'b0;
        if (b == 9) return 1'b1;
        return m_byte[b-1];
    endfunction

    task automatic check_bit(input string what, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b", cur_req, what, cycles, act, exp);
        end
    endtask

    // Per-cycle comparison after each falling edge.
    always @(negedge clk) begin
        #1;
        check_bit("line_out (R3 frame/R9 line)", line_out, model_line());
        check_bit("busy (R5)", busy, m_busy);
        check_bit("done (R6)", done, m_done);
    end

    // Watchdog and cycle counter.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog (R10 run length): actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic send(input bit [7:0] b);
        @(negedge clk);
        send_strobe = 1'b1;
        send_byte   = b;
        @(negedge clk);
        send_strobe = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!m_done);
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        idle_cycles(4);
        #2;
        check_bit("R1 reset line", line_out, 1'b1);
        check_bit("R1 reset busy", busy, 1'b0);
        rst_n = 1'b1;
        tx_enable = 1'b1;
        idle_cycles(3);

        // R2/R3/R5/R6: one full frame
        cur_req = "R2_R3_R5_R6";
        send(8'hA5);
        #2;
        check_bit("R2 busy after accept", busy, 1'b1);
        wait_done();
        #2;
        check_bit("R6 done with busy low", busy, 1'b0);
        idle_cycles(3);

        // R4: input changes during the frame have no effect
        cur_req = "R4";
        send(8'h3C);
        for (int i = 0; i < FRAME_CYC - 2; i++) begin
            send_byte = 8'(i * 37);
            @(negedge clk);
        end
        wait_done();
        idle_cycles(2);

        // R7: strobe while disabled is ignored
        cur_req = "R7";
        tx_enable = 1'b0;
        send(8'h0F);
        #2;
        check_bit("R7 busy stays low", busy, 1'b0);
        check_bit("R7 line stays high", line_out, 1'b1);
        tx_enable = 1'b1;
        idle_cycles(3);

        // R8: strobe while busy is ignored
        cur_req = "R8";
        send(8'h81);
        idle_cycles(3 * DIV);
        send(8'hFF);
        wait_done();
        idle_cycles(2);

        // R9: disable mid-frame abandons it
        cur_req = "R9";
        send(8'h5A);
        idle_cycles(4 * DIV + 3);
        tx_enable = 1'b0;
        #2;
        check_bit("R9 line high when disabled", line_out, 1'b1);
        @(negedge clk);
        #2;
        check_bit("R9 busy dropped", busy, 1'b0);
        idle_cycles(FRAME_CYC);
        tx_enable = 1'b1;
        idle_cycles(2);

        // R10: back-to-back frames from the done cycle
        cur_req = "R10";
        send(8'hC3);
        wait_done();
        send_strobe = 1'b1;
        send_byte   = 8'h96;
        @(negedge clk);
        send_strobe = 1'b0;
        #2;
        check_bit("R10 back-to-back accepted", busy, 1'b1);
        wait_done();
        idle_cycles(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule